// File: doc/BRIEF.md
# Multiplexed LCD display RAM loader

This block stores the segment pattern for a liquid-crystal panel driven with four backplanes. Its memory is a grid of 4 rows by 44 columns (176 bits). A column holds one bit per backplane, and each column feeds one segment output. An upstream bus front end supplies bytes one per clock. Each byte is split into two 4-bit vertical slices that land in two neighbouring columns. A column pointer chooses where the next byte goes and moves forward by itself.

The pointer is set with a load strobe and a start column. After that it moves two columns for every byte that is accepted. It stops at the end of the memory and never wraps back to column 0. If a byte arrives when only one column is left, its upper half is written and its lower half is lost. Bytes that arrive after the memory is full are dropped, and the stored data stays intact until the pointer is loaded again. A separate scanner reads the memory one column at a time through a registered read port. A synchronous clear empties the memory and sets the pointer back to column 0.

Top module: `lcd_dram_loader`

## Requirements
- R1: After reset, and in the cycle after `clr_i` is high, the pointer reads 0 and every column reads 0000.
- R2: When `ptr_ld_i` is high and `clr_i` is low, the pointer takes `ptr_addr_i` on the next edge. Any value of 44 or more becomes 44, which means full.
- R3: An accepted byte writes its upper nibble to the column at the pointer. Row r of that column gets data bit 7-r, so row 0 holds bit 7 and row 3 holds bit 4.
- R4: The lower nibble of the same byte goes to the column at pointer+1. Row r of that column gets data bit 3-r, so row 0 holds bit 3 and row 3 holds bit 0.
- R5: Each accepted byte moves the pointer forward by 2. Starting from 0, exactly 22 bytes fill all 44 columns and leave the pointer at 44. The pointer never goes above 44.
- R6: A byte accepted with the pointer at 43 writes only column 43. Its lower nibble is dropped and the pointer becomes 44.
- R7: While the pointer is 44, bytes are ignored. No column changes and the pointer stays at 44.
- R8: `clr_i` has priority over `ptr_ld_i`, and `ptr_ld_i` has priority over a write. A byte offered in the same cycle as a load or a clear is dropped. With no strobe and no write, the pointer holds its value.
- R9: `rd_data_o` shows column `rd_col_i` one cycle after the index is presented, with bit r holding row r. It shows the contents from before a write at the same edge. Any index of 44 or more reads 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| clr_i | input | 1 | Synchronous clear of the memory and the pointer |
| ptr_ld_i | input | 1 | Load strobe for the column pointer |
| ptr_addr_i | input | 6 | Start column for a load |
| wr_valid_i | input | 1 | Data byte is valid this cycle |
| wr_data_i | input | 8 | Data byte |
| rd_col_i | input | 6 | Column index for the read port |
| rd_data_o | output | 4 | Column contents, bit r is row r |
| ptr_o | output | 6 | Current column pointer, 44 when full |

## Verification
Pointer results appear on `ptr_o` one edge after the load, clear or write that causes them. A column written at one edge shows up on `rd_data_o` only after a read presented later. A read presented in the same cycle as the write returns the old contents one edge later. The bench drives every input 1 ns after a rising edge. It updates a behavioural model for that same edge and compares both outputs 1 ns after the edge, so every result is sampled in the exact cycle it is due. Reads that overlap a write check that the old contents come back, and the next read checks the new ones.

// File: rtl/lcd_dram_pkg.sv
package lcd_dram_pkg;
  localparam int unsigned LCD_ROWS = 4;
  localparam int unsigned LCD_COLS = 44;

  typedef enum logic [1:0] {
    PTR_HOLD  = 2'd0,
    PTR_CLEAR = 2'd1,
    PTR_LOAD  = 2'd2,
    PTR_STEP  = 2'd3
  } ptr_op_e;
endpackage

// File: rtl/lcd_col_ptr.sv
module lcd_col_ptr
  import lcd_dram_pkg::*;
#(
  parameter int unsigned COLS  = 44,
  parameter int unsigned PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             ld_i,
  input  logic [PTR_W-1:0] ld_addr_i,
  input  logic             step_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             full_o
);
  localparam logic [PTR_W:0]   FULL_X = (PTR_W+1)'(COLS);
  localparam logic [PTR_W-1:0] FULL_V = PTR_W'(COLS);

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [PTR_W:0]   step_sum;
  logic             ptr_en;
  ptr_op_e          op;

  assign full_o   = ({1'b0, ptr_q} >= FULL_X);
  assign step_sum = {1'b0, ptr_q} + (PTR_W+1)'(2);

  // operation select: clear, then load, then step
  always_comb begin
    if (clr_i)                 op = PTR_CLEAR;
    else if (ld_i)             op = PTR_LOAD;
    else if (step_i && !full_o) op = PTR_STEP;
    else                       op = PTR_HOLD;
  end

  always_comb begin
    ptr_en = (op != PTR_HOLD);
    case (op)
      PTR_CLEAR: ptr_d = '0;
      PTR_LOAD:  ptr_d = ({1'b0, ld_addr_i} >= FULL_X) ? FULL_V : ld_addr_i;
      PTR_STEP:  ptr_d = (step_sum >= FULL_X) ? FULL_V : step_sum[PTR_W-1:0];
      default:   ptr_d = ptr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/lcd_wr_map.sv
module lcd_wr_map #(
  parameter int unsigned ROWS  = 4,
  parameter int unsigned COLS  = 44,
  parameter int unsigned PTR_W = 6
) (
  input  logic                      wr_en_i,
  input  logic [PTR_W-1:0]          ptr_i,
  input  logic [2*ROWS-1:0]         data_i,
  output logic [COLS-1:0]           col_we_o,
  output logic [COLS-1:0][ROWS-1:0] col_wdata_o
);
  localparam int unsigned BYTE_W = 2 * ROWS;

  logic [ROWS-1:0] hi_nib, lo_nib;
  logic [PTR_W:0]  ptr_x, ptr_nxt;

  // vertical slices: the most significant bit of each half lands in row 0
  for (genvar r = 0; r < ROWS; r++) begin : g_rev
    assign hi_nib[r] = data_i[BYTE_W-1-r];
    assign lo_nib[r] = data_i[ROWS-1-r];
  end

  assign ptr_x   = {1'b0, ptr_i};
  assign ptr_nxt = ptr_x + (PTR_W+1)'(1);

  // the second column matches nothing past the end, so it is dropped there
  for (genvar c = 0; c < COLS; c++) begin : g_col
    localparam logic [PTR_W:0] CIDX = (PTR_W+1)'(c);
    logic hit_hi, hit_lo;
    assign hit_hi         = (ptr_x == CIDX);
    assign hit_lo         = (ptr_nxt == CIDX);
    assign col_we_o[c]    = wr_en_i & (hit_hi | hit_lo);
    assign col_wdata_o[c] = hit_hi ? hi_nib : lo_nib;
  end
endmodule

// File: rtl/lcd_col_mem.sv
module lcd_col_mem #(
  parameter int unsigned ROWS  = 4,
  parameter int unsigned COLS  = 44,
  parameter int unsigned PTR_W = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr_i,
  input  logic [COLS-1:0]           col_we_i,
  input  logic [COLS-1:0][ROWS-1:0] col_wdata_i,
  input  logic [PTR_W-1:0]          rd_col_i,
  output logic [ROWS-1:0]           rd_data_o
);
  logic [COLS-1:0][ROWS-1:0] mem_q;
  logic [ROWS-1:0]           rd_d, rd_q;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic            col_en;
    logic [ROWS-1:0] col_d, col_q;

    always_comb begin
      col_en = clr_i | col_we_i[c];
      col_d  = clr_i ? '0 : col_wdata_i[c];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      col_q <= '0;
      else if (col_en) col_q <= col_d;
    end

    assign mem_q[c] = col_q;
  end

  // column select; indices past the end leave the zero default
  always_comb begin
    rd_d = '0;
    for (int c = 0; c < COLS; c++) begin
      if (rd_col_i == PTR_W'(c)) rd_d = mem_q[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/lcd_dram_loader.sv
module lcd_dram_loader
  import lcd_dram_pkg::*;
#(
  parameter  int unsigned ROWS  = LCD_ROWS,
  parameter  int unsigned COLS  = LCD_COLS,
  localparam int unsigned PTR_W = $clog2(COLS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              ptr_ld_i,
  input  logic [PTR_W-1:0]  ptr_addr_i,
  input  logic              wr_valid_i,
  input  logic [2*ROWS-1:0] wr_data_i,
  input  logic [PTR_W-1:0]  rd_col_i,
  output logic [ROWS-1:0]   rd_data_o,
  output logic [PTR_W-1:0]  ptr_o
);
  logic [PTR_W-1:0]          ptr;
  logic                      full;
  logic                      wr_en;
  logic [COLS-1:0]           col_we;
  logic [COLS-1:0][ROWS-1:0] col_wdata;

  lcd_col_ptr #(.COLS(COLS), .PTR_W(PTR_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clr_i),
    .ld_i      (ptr_ld_i),
    .ld_addr_i (ptr_addr_i),
    .step_i    (wr_valid_i),
    .ptr_o     (ptr),
    .full_o    (full)
  );

  // a byte is committed only when no strobe competes and room is left
  assign wr_en = wr_valid_i & ~clr_i & ~ptr_ld_i & ~full;

  lcd_wr_map #(.ROWS(ROWS), .COLS(COLS), .PTR_W(PTR_W)) u_map (
    .wr_en_i     (wr_en),
    .ptr_i       (ptr),
    .data_i      (wr_data_i),
    .col_we_o    (col_we),
    .col_wdata_o (col_wdata)
  );

  lcd_col_mem #(.ROWS(ROWS), .COLS(COLS), .PTR_W(PTR_W)) u_mem (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (clr_i),
    .col_we_i    (col_we),
    .col_wdata_i (col_wdata),
    .rd_col_i    (rd_col_i),
    .rd_data_o   (rd_data_o)
  );

  assign ptr_o = ptr;
endmodule

// File: rtl/lcd_dram_loader_chk.sv
module lcd_dram_loader_chk #(
  parameter int unsigned ROWS  = 4,
  parameter int unsigned COLS  = 44,
  parameter int unsigned PTR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_i,
  input logic              ptr_ld_i,
  input logic [PTR_W-1:0]  ptr_addr_i,
  input logic              wr_valid_i,
  input logic [2*ROWS-1:0] wr_data_i,
  input logic [PTR_W-1:0]  rd_col_i,
  input logic [ROWS-1:0]   rd_data_o,
  input logic [PTR_W-1:0]  ptr_o
);
  logic unused_data;
  assign unused_data = ^wr_data_i;

  assert_clear_ptr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (ptr_o == '0));

  assert_load_clamp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_ld_i && !clr_i) |=>
      (ptr_o == (($past(ptr_addr_i) >= PTR_W'(COLS)) ? PTR_W'(COLS) : $past(ptr_addr_i))));

  assert_step_two_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && !ptr_ld_i && !clr_i && (ptr_o < PTR_W'(COLS - 1))) |=>
      (ptr_o == $past(ptr_o) + PTR_W'(2)));

  assert_ptr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_o <= PTR_W'(COLS));

  assert_last_col_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && !ptr_ld_i && !clr_i && (ptr_o == PTR_W'(COLS - 1))) |=>
      (ptr_o == PTR_W'(COLS)));

  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((ptr_o == PTR_W'(COLS)) && !ptr_ld_i && !clr_i) |=> (ptr_o == PTR_W'(COLS)));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_valid_i && !ptr_ld_i && !clr_i) |=> $stable(ptr_o));

  assert_oob_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_col_i >= PTR_W'(COLS)) |=> (rd_data_o == '0));
endmodule

bind lcd_dram_loader lcd_dram_loader_chk #(
  .ROWS(ROWS), .COLS(COLS), .PTR_W(PTR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr_i      (clr_i),
  .ptr_ld_i   (ptr_ld_i),
  .ptr_addr_i (ptr_addr_i),
  .wr_valid_i (wr_valid_i),
  .wr_data_i  (wr_data_i),
  .rd_col_i   (rd_col_i),
  .rd_data_o  (rd_data_o),
  .ptr_o      (ptr_o)
);

// File: tb/lcd_dram_loader_tb.sv
module lcd_dram_loader_tb;
  logic       clk;
  logic       rst_n;
  logic       clr_i;
  logic       ptr_ld_i;
  logic [5:0] ptr_addr_i;
  logic       wr_valid_i;
  logic [7:0] wr_data_i;
  logic [5:0] rd_col_i;
  logic [3:0] rd_data_o;
  logic [5:0] ptr_o;

  int tests;
  int fails;
  bit done;

  // behavioural reference
  logic [3:0] m [44];
  int         mptr;

  lcd_dram_loader u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr_i),
    .ptr_ld_i   (ptr_ld_i),
    .ptr_addr_i (ptr_addr_i),
    .wr_valid_i (wr_valid_i),
    .wr_data_i  (wr_data_i),
    .rd_col_i   (rd_col_i),
    .rd_data_o  (rd_data_o),
    .ptr_o      (ptr_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  // advance one clock: update model, then compare pointer and read data
  task automatic step(input string tag);
    int exp_rd;
    exp_rd = 0;
    if (rd_col_i < 44) exp_rd = int'(m[rd_col_i]);
    if (clr_i) begin
      foreach (m[i]) m[i] = 4'h0;
      mptr = 0;
    end else if (ptr_ld_i) begin
      mptr = (ptr_addr_i > 43) ? 44 : int'(ptr_addr_i);
    end else if (wr_valid_i && mptr < 44) begin
      for (int r = 0; r < 4; r++) m[mptr][r] = wr_data_i[7-r];
      if (mptr + 1 < 44)
        for (int r = 0; r < 4; r++) m[mptr+1][r] = wr_data_i[3-r];
      mptr = (mptr + 2 > 44) ? 44 : mptr + 2;
    end
    @(posedge clk);
    #1;
    check(tag, "ptr_o", int'(ptr_o), mptr);
    check(tag, "rd_data_o", int'(rd_data_o), exp_rd);
    clr_i = 1'b0; ptr_ld_i = 1'b0; wr_valid_i = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d, input string tag);
    wr_valid_i = 1'b1; wr_data_i = d; step(tag);
  endtask

  task automatic ld(input int a, input string tag);
    ptr_ld_i = 1'b1; ptr_addr_i = 6'(a); step(tag);
  endtask

  task automatic rd(input int c, input string tag);
    rd_col_i = 6'(c); step(tag);
  endtask

  task automatic read_all(input string tag);
    for (int c = 0; c < 44; c++) rd(c, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (R1..): actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    tests = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; clr_i = 1'b0; ptr_ld_i = 1'b0; ptr_addr_i = '0;
    wr_valid_i = 1'b0; wr_data_i = '0; rd_col_i = '0;
    foreach (m[i]) m[i] = 4'h0;
    mptr = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state
    check("R1", "ptr_o", int'(ptr_o), 0);
    check("R1", "rd_data_o", int'(rd_data_o), 0);
    read_all("R1");

    // R5, R3, R4: fill from column 0
    for (int i = 0; i < 22; i++) wr(8'((i * 37 + 5) & 255), "R5");
    for (int c = 0; c < 44; c += 2) begin
      rd(c, "R3");
      rd(c + 1, "R4");
    end

    // R7: full memory drops bytes, no wrap
    wr(8'h3C, "R7"); wr(8'hC3, "R7"); wr(8'hFF, "R7");
    read_all("R7");

    // R6: a single column left
    ld(43, "R2");
    wr(8'hA5, "R6");
    rd(43, "R6");
    rd(42, "R6");
    wr(8'h00, "R7");
    rd(43, "R7");

    // R2: clamp above the end
    ld(60, "R2");
    wr(8'hFF, "R7");
    rd(0, "R7");

    // R9: out-of-range reads and read-before-write
    rd(44, "R9");
    rd(63, "R9");
    ld(0, "R2");
    rd_col_i = 6'd0; wr(8'h96, "R9");
    rd(0, "R9");
    rd(1, "R9");

    // R1: synchronous clear
    clr_i = 1'b1; step("R1");
    read_all("R1");

    // odd start column
    ld(5, "R2");
    wr(8'h96, "R3");
    wr(8'h5A, "R4");
    for (int c = 4; c < 10; c++) rd(c, "R4");

    // R8: priority
    ptr_ld_i = 1'b1; ptr_addr_i = 6'd20; wr_valid_i = 1'b1; wr_data_i = 8'hFF;
    step("R8");
    rd(20, "R8");
    rd(21, "R8");
    step("R8");
    clr_i = 1'b1; ptr_ld_i = 1'b1; ptr_addr_i = 6'd9; wr_valid_i = 1'b1; wr_data_i = 8'hFF;
    step("R8");
    rd(0, "R8");
    rd(5, "R8");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule